// File: doc/BRIEF.md
# Flash Program/Erase Command Controller

This block sits between a simple single-beat register bus and an embedded flash array. It runs three kinds of operation on that array: erasing one page, programming a run of adjacent words from a staging buffer, and fetching one word from a small information bank. The array is modelled behaviourally inside the block, so the controller and its storage form one unit. The storage is two main banks plus one information bank of a single page.

Firmware arms an operation in two steps. It first writes a fixed unlock value, then writes an operation code to one of two per-bank command registers. The word offset, the bank selection and the word count come from a shared transaction register. While an erase or program is running, its command register reads back the operation code. It returns to zero when the operation is done. Any bus read of the main-array window that falls in the bank being worked on is held off by keeping ready low until the operation completes. Reads of the other bank and of the registers are not held off. Retries, pulse timing and retry policy are left to software.

The page size, pages per bank, erase duration and program duration are parameters. By default a page is 512 words, each bank has 2 pages, an erase takes 64 cycles and a program takes 16 cycles.

Top module: `flash_pe_ctrl`

## Requirements
- R1: Writing 0xB11924E1 to the unlock register (register index 0) and then a valid operation code to command register 1 or 2 starts the operation. The valid codes are 0x31415927 for page erase, 0x27182818 for program and 0x16021765 for an info-bank word fetch. That command register reads the code for exactly ERASE_CYCLES (erase), PROG_CYCLES (program) or 1 (fetch) consecutive bus reads that start right after the write, and reads 0 afterwards. Both command registers read 0 after reset.
- R2: A valid code written to a command register while the unlock value is not armed starts nothing and sets error bit 0 in the error register (index 4).
- R3: Any write to a command register disarms the unlock, including a write of a value that is not a valid code. A value that is not a valid code is ignored and starts nothing. A valid code written after such a write sets error bit 0 and starts nothing.
- R4: An erase sets all words of the page that contains the word offset to 0xFFFFFFFF. Other pages keep their contents.
- R5: A program operation updates words offset through offset+N, where N is the count field. Each updated word becomes its old value AND the staging-buffer word (buffer index k at register index 32+k). Words outside that range keep their contents.
- R6: A program whose range would pass the end of the offset's page starts nothing, sets error bit 1 and leaves the array unchanged.
- R7: A fetch stores the addressed info-bank word in the read-value register (index 5). A fetch code written while the info-bank select is clear starts nothing and sets error bit 2.
- R8: While an erase or program runs on main bank b, a bus read in the array window for bank b has ready held low until the operation completes. The read then returns the updated data. Reads of the other bank and of registers are never held off.
- R9: A bus read of the error register returns its bits and clears them.
- R10: A valid code written to either command register while an operation is running is ignored.
- R11: The transaction register (index 3) holds the word offset in bits 15:0, the info-bank select in bit 16 and the zero-based count in bits 21:17. When the select is set, the operation targets the info bank, whichever command register was used. Otherwise command register 1 targets main bank 0 and command register 2 targets main bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Transfer request |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Word address. The top bit selects the array window (bank in the next bit, word below it). Otherwise the register index is in bits 5:0 |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busReady is high |
| busReady | output | 1 | Transfer completes at the clock edge where busSel and busReady are both high |

## Verification
Two functions can fall in the same cycle: an operation completing, and a stalled array read of the same bank being released. The read must come out in the cycle right after completion and carry the post-operation contents. The bench provokes this by issuing an array read of bank 1 immediately after launching an erase there. It then judges the stall length against ERASE_CYCLES and the returned word against the erased value. The bench also issues a read of bank 0 during a bank 1 erase, and checks that this read sees zero wait cycles.

// File: rtl/flash_pe_pkg.sv
`timescale 1ns/1ps
package flash_pe_pkg;
  localparam logic [31:0] UNLOCK_VAL = 32'hB119_24E1;
  localparam logic [31:0] OP_ERASE   = 32'h3141_5927;
  localparam logic [31:0] OP_PROG    = 32'h2718_2818;
  localparam logic [31:0] OP_FETCH   = 32'h1602_1765;

  localparam int BUF_WORDS = 32;
  localparam int CNT_FW    = $clog2(BUF_WORDS);
  localparam int OFF_W     = 16;
  localparam int ERR_W     = 3;
  localparam int ERR_NOKEY = 0;
  localparam int ERR_CROSS = 1;
  localparam int ERR_FETCH = 2;

  typedef enum logic [1:0] {
    TGT_MAIN0 = 2'd0,
    TGT_MAIN1 = 2'd1,
    TGT_INFO  = 2'd2
  } target_e;

  typedef struct packed {
    logic              doErase;
    logic              doProg;
    logic              doFetch;
    target_e           target;
    logic [OFF_W-1:0]  offset;
    logic [CNT_FW-1:0] lastIdx;
  } cmd_t;
endpackage

// File: rtl/flash_pe_seq.sv
`timescale 1ns/1ps
module flash_pe_seq
  import flash_pe_pkg::*;
#(
  parameter int PAGE_WORDS   = 512,
  parameter int ERASE_CYCLES = 64,
  parameter int PROG_CYCLES  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [5:0]       regIdx,
  input  logic [31:0]      wdata,
  output cmd_t             cmd,
  output logic             busy,
  output target_e          busyTarget,
  output logic [31:0]      ctrlVal0,
  output logic [31:0]      ctrlVal1,
  output logic [31:0]      transVal,
  output logic [ERR_W-1:0] errVal
);
  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic              keyArmed;
  logic [31:0]       transQ;
  logic [ERR_W-1:0]  errQ;
  logic              opSlot;
  logic [31:0]       opCode;
  target_e           opTarget;
  logic [OFF_W-1:0]  opOffset;
  logic [CNT_FW-1:0] opLast;
  logic [CNT_W-1:0]  cnt;

  logic              isCmdWr, validOp, crosses, launch, finish;
  target_e           reqTarget;
  logic [ERR_W-1:0]  setErr;
  logic [CNT_W-1:0]  launchCyc;
  logic [OFF_W-1:0]  transOffset;
  logic              transInfo;
  logic [CNT_FW-1:0] transLast;

  assign transOffset = transQ[15:0];
  assign transInfo   = transQ[16];
  assign transLast   = transQ[21:17];

  always_comb begin
    isCmdWr   = regWr && (regIdx == 6'd1 || regIdx == 6'd2);
    validOp   = (wdata == OP_ERASE) || (wdata == OP_PROG) || (wdata == OP_FETCH);
    reqTarget = transInfo ? TGT_INFO : ((regIdx == 6'd2) ? TGT_MAIN1 : TGT_MAIN0);
    crosses   = ((int'(transOffset) % PAGE_WORDS) + int'(transLast)) >= PAGE_WORDS;
    setErr    = '0;
    launch    = 1'b0;
    if (isCmdWr && !busy && validOp) begin
      if (!keyArmed)                                  setErr[ERR_NOKEY] = 1'b1;
      else if (wdata == OP_PROG && crosses)           setErr[ERR_CROSS] = 1'b1;
      else if (wdata == OP_FETCH && reqTarget != TGT_INFO) setErr[ERR_FETCH] = 1'b1;
      else                                            launch = 1'b1;
    end
    if (wdata == OP_ERASE)     launchCyc = CNT_W'(ERASE_CYCLES);
    else if (wdata == OP_PROG) launchCyc = CNT_W'(PROG_CYCLES);
    else                       launchCyc = CNT_W'(1);
  end

  assign finish        = busy && (cnt == CNT_W'(1));
  assign cmd.doErase   = finish && (opCode == OP_ERASE);
  assign cmd.doProg    = finish && (opCode == OP_PROG);
  assign cmd.doFetch   = finish && (opCode == OP_FETCH);
  assign cmd.target    = opTarget;
  assign cmd.offset    = opOffset;
  assign cmd.lastIdx   = opLast;
  assign busyTarget    = opTarget;
  assign ctrlVal0      = (busy && !opSlot) ? opCode : 32'd0;
  assign ctrlVal1      = (busy &&  opSlot) ? opCode : 32'd0;
  assign transVal      = transQ;
  assign errVal        = errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyArmed <= 1'b0;
      transQ   <= '0;
      errQ     <= '0;
      busy     <= 1'b0;
      opSlot   <= 1'b0;
      opCode   <= '0;
      opTarget <= TGT_MAIN0;
      opOffset <= '0;
      opLast   <= '0;
      cnt      <= '0;
    end else begin
      if (regWr && regIdx == 6'd0) keyArmed <= (wdata == UNLOCK_VAL);
      else if (isCmdWr)            keyArmed <= 1'b0;
      if (regWr && regIdx == 6'd3) transQ <= wdata;
      errQ <= ((regRd && regIdx == 6'd4) ? '0 : errQ) | setErr;
      if (launch) begin
        busy     <= 1'b1;
        cnt      <= launchCyc;
        opCode   <= wdata;
        opSlot   <= (regIdx == 6'd2);
        opTarget <= reqTarget;
        opOffset <= transOffset;
        opLast   <= transLast;
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_pe_store.sv
`timescale 1ns/1ps
module flash_pe_store
  import flash_pe_pkg::*;
#(
  parameter int PAGE_WORDS = 512,
  parameter int BANK_PAGES = 2,
  localparam int BANK_WORDS = PAGE_WORDS * BANK_PAGES,
  localparam int BANK_AW    = $clog2(BANK_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  cmd_t               cmd,
  input  logic               bufWr,
  input  logic [CNT_FW-1:0]  bufIdx,
  input  logic [31:0]        wdata,
  input  logic               rdBank,
  input  logic [BANK_AW-1:0] rdWord,
  output logic [31:0]        arrData,
  output logic [31:0]        readVal
);
  logic [31:0] wbuf [BUF_WORDS];
  logic [31:0] bankRd [2];

  always_ff @(posedge clk) begin
    if (bufWr) wbuf[bufIdx] <= wdata;
  end

  for (genvar b = 0; b < 3; b++) begin : tgtG
    localparam int DEPTH = (b == 2) ? PAGE_WORDS : BANK_WORDS;
    localparam int IW    = $clog2(DEPTH);
    logic [31:0] mem [DEPTH];
    int wordBase, pageBase;

    always_comb begin
      wordBase = int'(cmd.offset) % DEPTH;
      pageBase = (wordBase / PAGE_WORDS) * PAGE_WORDS;
    end

    always_ff @(posedge clk) begin
      if (cmd.target == target_e'(b)) begin
        if (cmd.doErase)
          for (int w = 0; w < PAGE_WORDS; w++) mem[IW'(pageBase + w)] <= '1;
        if (cmd.doProg)
          for (int i = 0; i < BUF_WORDS; i++)
            if (i <= int'(cmd.lastIdx))
              mem[IW'(wordBase + i)] <= mem[IW'(wordBase + i)] & wbuf[i];
      end
    end

    if (b == 2) begin : infoG
      always_ff @(posedge clk) begin
        if (!rstN) readVal <= '0;
        else if (cmd.doFetch) readVal <= mem[IW'(wordBase)];
      end
    end else begin : mainG
      assign bankRd[b] = mem[rdWord];
    end
  end

  assign arrData = bankRd[rdBank];
endmodule

// File: rtl/flash_pe_ctrl.sv
`timescale 1ns/1ps
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int PAGE_WORDS   = 512,
  parameter int BANK_PAGES   = 2,
  parameter int ERASE_CYCLES = 64,
  parameter int PROG_CYCLES  = 16,
  parameter int ADDR_W       = $clog2(PAGE_WORDS * BANK_PAGES) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busReady
);
  localparam int BANK_AW = $clog2(PAGE_WORDS * BANK_PAGES);

  logic             arraySel, arrBank, regHit, stall, xfer, regWr, regRd;
  logic [5:0]       regIdx;
  cmd_t             cmd;
  logic             busy;
  target_e          busyTarget;
  logic [31:0]      ctrlVal0, ctrlVal1, transVal, arrData, readVal;
  logic [ERR_W-1:0] errVal;

  assign arraySel = busAddr[ADDR_W-1];
  assign arrBank  = busAddr[BANK_AW];
  assign regIdx   = busAddr[5:0];
  assign regHit   = !arraySel && (busAddr[ADDR_W-2:6] == '0);
  assign stall    = busSel && !busWrite && arraySel && busy &&
                    (busyTarget == (arrBank ? TGT_MAIN1 : TGT_MAIN0));
  assign busReady = !stall;
  assign xfer     = busSel && busReady;
  assign regWr    = xfer && busWrite && regHit;
  assign regRd    = xfer && !busWrite && regHit;

  flash_pe_seq #(
    .PAGE_WORDS(PAGE_WORDS), .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) uSeq (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regIdx(regIdx),
    .wdata(busWdata), .cmd(cmd), .busy(busy), .busyTarget(busyTarget),
    .ctrlVal0(ctrlVal0), .ctrlVal1(ctrlVal1), .transVal(transVal), .errVal(errVal)
  );

  flash_pe_store #(
    .PAGE_WORDS(PAGE_WORDS), .BANK_PAGES(BANK_PAGES)
  ) uStore (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bufWr(regWr && regIdx[5]),
    .bufIdx(regIdx[4:0]), .wdata(busWdata), .rdBank(arrBank),
    .rdWord(busAddr[BANK_AW-1:0]), .arrData(arrData), .readVal(readVal)
  );

  always_comb begin
    busRdata = 32'd0;
    if (arraySel) busRdata = arrData;
    else if (regHit) begin
      case (regIdx)
        6'd1:    busRdata = ctrlVal0;
        6'd2:    busRdata = ctrlVal1;
        6'd3:    busRdata = transVal;
        6'd4:    busRdata = {{(32-ERR_W){1'b0}}, errVal};
        6'd5:    busRdata = readVal;
        default: busRdata = 32'd0;
      endcase
    end
  end
endmodule

module flash_pe_ctrl_chk
  import flash_pe_pkg::*;
#(
  parameter int PAGE_WORDS = 512
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWrite,
  input logic             arraySel,
  input logic             arrBank,
  input logic             busReady,
  input logic             busy,
  input target_e          busyTarget,
  input cmd_t             cmd,
  input logic             regRd,
  input logic [5:0]       regIdx,
  input logic [ERR_W-1:0] errVal
);
  logic anyDone;
  assign anyDone = cmd.doErase || cmd.doProg || cmd.doFetch;

  assert_busy_bank_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && arraySel && busy &&
     busyTarget == (arrBank ? TGT_MAIN1 : TGT_MAIN0)) |-> !busReady);

  assert_regs_never_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !arraySel) |-> busReady);

  assert_single_action_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.doErase, cmd.doProg, cmd.doFetch}));

  assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    anyDone |=> !busy);

  assert_err_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regIdx == 6'd4) |=> (errVal == '0));

  assert_prog_in_page_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doProg |-> ((int'(cmd.offset) % PAGE_WORDS) + int'(cmd.lastIdx) < PAGE_WORDS));

  assert_fetch_info_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doFetch |-> (cmd.target == TGT_INFO));
endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk #(.PAGE_WORDS(PAGE_WORDS)) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .arraySel(arraySel), .arrBank(arrBank), .busReady(busReady), .busy(busy),
  .busyTarget(busyTarget), .cmd(cmd), .regRd(regRd), .regIdx(regIdx), .errVal(errVal)
);

// File: tb/flash_pe_ctrl_test.sv
`timescale 1ns/1ps
module flash_pe_ctrl_test;
  localparam int ERASE_N = 64;
  localparam int PROG_N  = 16;
  localparam logic [11:0] A_KEY = 12'h000, A_C0 = 12'h001, A_C1 = 12'h002,
                          A_TR = 12'h003, A_ERR = 12'h004, A_RV = 12'h005, A_BUF = 12'h020;
  localparam logic [31:0] KEY = 32'hB119_24E1, OPE = 32'h3141_5927,
                          OPP = 32'h2718_2818, OPF = 32'h1602_1765;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, busSel = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busReady;

  flash_pe_ctrl uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady)
  );

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t expQ[$];
  bit chkOn = 1'b0;
  int nRun = 0, nFail = 0;

  always @(negedge clk) begin
    if (chkOn && busSel && !busWrite && busReady) begin
      exp_t e;
      e = expQ.pop_front();
      nRun++;
      if (busRdata !== e.exp) begin
        nFail++;
        $display("FAIL %s: actual %h expected %h", e.tag, busRdata, e.exp);
      end
    end
  end

  function automatic logic [11:0] arr(input int bank, input int word);
    return 12'h800 | 12'(bank << 10) | 12'(word);
  endfunction

  function automatic logic [31:0] tr(input int off, input bit info, input int last);
    return {10'd0, 5'(last), info, 16'(off)};
  endfunction

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    while (1) begin @(negedge clk); if (busReady) break; end
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d, output int waits);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; waits = 0;
    while (1) begin @(negedge clk); if (busReady) break; waits++; end
    d = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0; chkOn = 1'b0;
  endtask

  task automatic expectRd(input logic [11:0] a, input logic [31:0] exp, input string tag,
                          output int waits);
    logic [31:0] d;
    exp_t e;
    e.exp = exp; e.tag = tag;
    expQ.push_back(e);
    chkOn = 1'b1;
    busRd(a, d, waits);
  endtask

  task automatic expect0(input logic [11:0] a, input logic [31:0] exp, input string tag);
    int w;
    expectRd(a, exp, tag, w);
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pollDone(input logic [11:0] a, output int n);
    logic [31:0] v;
    int w;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      busRd(a, v, w);
      if (v == 32'd0) break;
      n++;
    end
  endtask

  task automatic launch(input logic [11:0] c, input logic [31:0] op);
    busWr(A_KEY, KEY);
    busWr(c, op);
  endtask

  logic [31:0] pat [4];
  logic [31:0] q;

  initial begin
    int n, w;
    pat[0] = 32'h0F0F_1234; pat[1] = 32'hFFFF_0000;
    pat[2] = 32'h1357_9BDF; pat[3] = 32'hC3C3_3C3C;
    q = 32'h00FF_FF0F;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // reset state (R1, R9, R11)
    expect0(A_C0, 32'd0, "R1 ctrl0 after reset");
    expect0(A_C1, 32'd0, "R1 ctrl1 after reset");
    expect0(A_ERR, 32'd0, "R9 err after reset");
    expect0(A_TR, 32'd0, "R11 trans after reset");

    // R2: opcode without unlock
    busWr(A_TR, tr(0, 1'b0, 0));
    busWr(A_C0, OPE);
    expect0(A_C0, 32'd0, "R2 no start without key");
    expect0(A_ERR, 32'd1, "R2 nokey error bit");
    expect0(A_ERR, 32'd0, "R9 error cleared by read");

    // R1/R4: erase bank0 page0 and page1
    launch(A_C0, OPE);
    pollDone(A_C0, n);
    checkVal("R1 erase busy length", n, ERASE_N);
    busWr(A_TR, tr(512, 1'b0, 0));
    launch(A_C0, OPE);
    pollDone(A_C0, n);

    // R8: stalled read of busy bank1, released with erased data
    busWr(A_TR, tr(0, 1'b0, 0));
    launch(A_C1, OPE);
    expectRd(arr(1, 5), 32'hFFFF_FFFF, "R8 stalled read sees erased word", w);
    checkVal("R8 stall length equals erase", w, ERASE_N);
    expect0(A_C1, 32'd0, "R1 ctrl1 idle after erase");

    // R8: other bank not stalled
    busWr(A_TR, tr(512, 1'b0, 0));
    launch(A_C1, OPE);
    expectRd(arr(0, 0), 32'hFFFF_FFFF, "R8 other bank read", w);
    checkVal("R8 other bank no stall", w, 0);
    expect0(A_C1, OPE, "R1 ctrl1 shows opcode while busy");
    pollDone(A_C1, n);

    // R5: program four words at offset 8
    for (int i = 0; i < 4; i++) busWr(A_BUF + 12'(i), pat[i]);
    busWr(A_TR, tr(8, 1'b0, 3));
    launch(A_C0, OPP);
    pollDone(A_C0, n);
    checkVal("R1 program busy length", n, PROG_N);
    for (int i = 0; i < 4; i++) expect0(arr(0, 8 + i), pat[i], "R5 programmed word");
    expect0(arr(0, 12), 32'hFFFF_FFFF, "R5 word past count untouched");
    expect0(arr(0, 7), 32'hFFFF_FFFF, "R5 word before offset untouched");
    busWr(A_BUF, q);
    busWr(A_TR, tr(8, 1'b0, 0));
    launch(A_C0, OPP);
    pollDone(A_C0, n);
    expect0(arr(0, 8), pat[0] & q, "R5 reprogram ANDs");
    expect0(arr(0, 9), pat[1], "R5 single-word count");

    // R6: page crossing rejected
    busWr(A_BUF, 32'd0);
    busWr(A_TR, tr(510, 1'b0, 3));
    launch(A_C0, OPP);
    expect0(A_C0, 32'd0, "R6 crossing not started");
    expect0(A_ERR, 32'd2, "R6 crossing error bit");
    expect0(arr(0, 510), 32'hFFFF_FFFF, "R6 array unchanged");

    // R3: key consumed by invalid write
    busWr(A_TR, tr(8, 1'b0, 0));
    launch(A_C0, 32'h1234_5678);
    expect0(A_C0, 32'd0, "R3 invalid value ignored");
    busWr(A_C0, OPP);
    expect0(A_C0, 32'd0, "R3 no start after consumed key");
    expect0(A_ERR, 32'd1, "R3 nokey after consumed key");
    expect0(arr(0, 8), pat[0] & q, "R3 array unchanged");

    // R10: command while busy ignored; R4 other page untouched
    busWr(A_TR, tr(512, 1'b0, 0));
    launch(A_C0, OPE);
    launch(A_C1, OPP);
    expect0(A_C1, 32'd0, "R10 second command ignored");
    pollDone(A_C0, n);
    expect0(A_ERR, 32'd0, "R10 no error for ignored command");
    expect0(arr(1, 512), 32'hFFFF_FFFF, "R10 bank1 unchanged");
    expect0(arr(0, 8), pat[0] & q, "R4 other page keeps data");

    // R11/R7: info bank via info select
    busWr(A_TR, tr(4, 1'b1, 0));
    launch(A_C0, OPE);
    pollDone(A_C0, n);
    busWr(A_BUF, 32'hA5A5_5A5A);
    launch(A_C1, OPP);
    pollDone(A_C1, n);
    launch(A_C1, OPF);
    pollDone(A_C1, n);
    checkVal("R1 fetch busy length", n, 1);
    expect0(A_RV, 32'hA5A5_5A5A, "R7 fetched info word");
    expect0(arr(0, 4), 32'hFFFF_FFFF, "R11 main bank untouched by info ops");
    busWr(A_TR, tr(4, 1'b0, 0));
    launch(A_C0, OPF);
    expect0(A_C0, 32'd0, "R7 fetch on main not started");
    expect0(A_ERR, 32'd4, "R7 fetch on main error bit");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule